// File: doc/BRIEF.md
# Framed Serial Instruction Loader

This block sits behind a byte-wide serial receiver and fills an on-chip instruction memory with 64-bit words. Each byte that arrives carries seven payload bits. Its most significant bit is a marker that opens a new group. Ten bytes make one 64-bit group, and a record is two such groups: the destination slot first, then the instruction word. When the last byte of a record is accepted, the block issues one write on its memory port.

The destination comes from the record itself, never from a running counter. A host can therefore patch any single slot by sending that slot's record again. Because of the marker bit, a receiver that has lost its place finds the next group boundary by itself. Malformed traffic is dropped and reported on an error pulse: a continuation byte with no group open, or a new start while a group is half filled.

Top module: `frame_loader`

## Requirements
- R1: After synchronous active-high reset, `mem_we`, `err_pulse` and `done_pulse` are low, `mem_addr` and `mem_data` are zero, and the block expects the first group of a record (the address group).
- R2: In each accepted byte, bit 7 is the marker and bits 6:0 are the payload. A group opens on a byte with marker 1 and continues only on bytes with marker 0.
- R3: A group is ten bytes, with the most significant chunk first. Its value is the low 64 bits of the 70-bit concatenation of the ten payloads, so the top six bits of the first chunk are dropped.
- R4: When the tenth byte of the instruction group is accepted on a clock edge, `mem_we` is high for exactly the one following cycle. In that cycle `mem_data` holds the instruction group value.
- R5: `done_pulse` is high in exactly the cycles in which `mem_we` is high.
- R6: A marker-1 byte that arrives while a group is partly filled discards the partial value and starts the same kind of group again. `err_pulse` is high for the one following cycle. An address already completed for the record is kept.
- R7: A marker-0 byte that arrives while no group is open is ignored, and `err_pulse` is high for the one following cycle.
- R8: `mem_addr` during a write equals the low `ADDR_W` bits of the value of that record's address group. Sending another record with the same address writes that slot again.
- R9: A cycle with `rx_valid` low changes nothing and produces no write and no error.
- R10: A marker-1 byte accepted in the cycle in which the previous record's write is on the port is taken as the start of the next record, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_byte | input | 8 | Received byte: marker in bit 7, payload in bits 6:0 |
| rx_valid | input | 1 | Qualifies `rx_byte` for one cycle |
| mem_addr | output | ADDR_W | Slot of the instruction memory being written |
| mem_data | output | 64 | Instruction word to write |
| mem_we | output | 1 | One-cycle write strobe |
| err_pulse | output | 1 | One-cycle pulse for a stray or restarting byte |
| done_pulse | output | 1 | One-cycle pulse when a record has been written |

## Verification
The memory write of one record can fall in the same cycle as the acceptance of the next record's start byte. The bench provokes this on every record, because it presents bytes on consecutive cycles with no gap after the twentieth. In that overlap it checks that the write carries the old record's slot and data, and that the new start byte is counted as the first chunk of a fresh address group. Constrained random traffic also inserts stray continuation bytes and early start bytes close to record boundaries. Every output is compared cycle by cycle against a bench model derived from the framing rules.

// File: rtl/lod_pkg.sv
package lod_pkg;

    localparam int WORD_W  = 64;
    localparam int CHUNK_W = 7;
    localparam int BYTE_W  = CHUNK_W + 1;
    localparam int CHUNKS  = (WORD_W + CHUNK_W - 1) / CHUNK_W;
    localparam int CNT_W   = $clog2(CHUNKS + 1);

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [CHUNK_W-1:0] chunk_t;
    typedef logic [CNT_W-1:0]   cnt_t;

    // one received symbol: marker on top, payload below
    typedef struct packed {
        logic   lead;
        chunk_t chunk;
    } rx_sym_t;

    // which group of a record is being collected
    typedef enum logic {
        GRP_ADDR = 1'b0,
        GRP_INSN = 1'b1
    } grp_kind_e;

    // per-byte events reported by the assembler
    typedef struct packed {
        logic complete;
        logic restart;
        logic stray;
    } asm_evt_t;

    function automatic word_t shift_chunk(input word_t acc, input chunk_t c);
        return {acc[WORD_W-CHUNK_W-1:0], c};
    endfunction

    function automatic word_t seed_chunk(input chunk_t c);
        return {{(WORD_W-CHUNK_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/lod_group_asm.sv
module lod_group_asm
    import lod_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sym_valid,
    input  rx_sym_t  sym,
    output asm_evt_t evt,
    output word_t    value
);

    localparam cnt_t LAST_CNT = cnt_t'(CHUNKS - 1);
    localparam cnt_t ONE_CNT  = cnt_t'(1);

    word_t acc_q;
    cnt_t  cnt_q;
    logic  open_w;

    assign open_w = (cnt_q != '0);

    always_comb begin
        value        = shift_chunk(acc_q, sym.chunk);
        evt.restart  = sym_valid &  sym.lead &  open_w;
        evt.stray    = sym_valid & ~sym.lead & ~open_w;
        evt.complete = sym_valid & ~sym.lead &  open_w & (cnt_q == LAST_CNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (sym_valid) begin
            if (sym.lead) begin
                acc_q <= seed_chunk(sym.chunk);
                cnt_q <= ONE_CNT;
            end else if (open_w) begin
                acc_q <= value;
                cnt_q <= evt.complete ? cnt_t'(0) : cnt_q + ONE_CNT;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_CNT);                                          // R3

    AST_LEAD_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym.lead) |=> (cnt_q == ONE_CNT));             // R6

    AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        evt.stray |=> (cnt_q == '0) && $stable(acc_q));              // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> $stable(cnt_q) && $stable(acc_q));            // R9

endmodule

// File: rtl/lod_record_ctl.sv
module lod_record_ctl
    import lod_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_valid,
    input  asm_evt_t          evt,
    input  word_t             value,
    output logic [ADDR_W-1:0] mem_addr,
    output word_t             mem_data,
    output logic              mem_we,
    output logic              err_pulse,
    output logic              done_pulse
);

    grp_kind_e         kind_q;
    logic [ADDR_W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q     <= GRP_ADDR;
            slot_q     <= '0;
            mem_addr   <= '0;
            mem_data   <= '0;
            mem_we     <= 1'b0;
            err_pulse  <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            mem_we     <= 1'b0;
            done_pulse <= 1'b0;
            err_pulse  <= evt.restart | evt.stray;
            if (evt.complete) begin
                if (kind_q == GRP_ADDR) begin
                    slot_q <= value[ADDR_W-1:0];
                    kind_q <= GRP_INSN;
                end else begin
                    mem_addr   <= slot_q;
                    mem_data   <= value;
                    mem_we     <= 1'b1;
                    done_pulse <= 1'b1;
                    kind_q     <= GRP_ADDR;
                end
            end
        end
    end

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);                                         // R4

    AST_WE_AFTER_INSN: assert property (@(posedge clk) disable iff (rst)
        (evt.complete && kind_q == GRP_INSN) |=> mem_we && (mem_addr == $past(slot_q))); // R8

    AST_ADDR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (evt.complete && kind_q == GRP_ADDR) |=> !mem_we && (kind_q == GRP_INSN)); // R8

    AST_DONE_TRACKS_WE: assert property (@(posedge clk) disable iff (rst)
        done_pulse == mem_we);                                       // R5

    AST_ERR_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(err_pulse && mem_we));                                     // R6

    AST_QUIET_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> !mem_we && !err_pulse);                       // R9

endmodule

// File: rtl/frame_loader.sv
module frame_loader
    import lod_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_data,
    output logic              mem_we,
    output logic              err_pulse,
    output logic              done_pulse
);

    rx_sym_t  sym_w;
    asm_evt_t evt_w;
    word_t    value_w;

    assign sym_w = rx_sym_t'(rx_byte);

    lod_group_asm u_asm (
        .clk       (clk),
        .rst       (rst),
        .sym_valid (rx_valid),
        .sym       (sym_w),
        .evt       (evt_w),
        .value     (value_w)
    );

    lod_record_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .sym_valid  (rx_valid),
        .evt        (evt_w),
        .value      (value_w),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .mem_we     (mem_we),
        .err_pulse  (err_pulse),
        .done_pulse (done_pulse)
    );

endmodule

// File: tb/frame_loader_tb.sv
`timescale 1ns/1ps
module frame_loader_tb_top;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    rx_byte = 8'h00;
    logic          rx_valid = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_data;
    logic          mem_we;
    logic          err_pulse;
    logic          done_pulse;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // bench model state
    int            m_cnt  = 0;
    logic [63:0]   m_acc  = '0;
    bit            m_insn = 1'b0;
    logic [AW-1:0] m_slot = '0;

    always #2.5 clk = ~clk;

    frame_loader #(.ADDR_W(AW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .mem_we     (mem_we),
        .err_pulse  (err_pulse),
        .done_pulse (done_pulse)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] sym_of(input logic [63:0] v, input int i);
        logic [63:0] s;
        s = v >> (7 * (9 - i));
        return {(i == 0), s[6:0]};
    endfunction

    // drive one cycle at a negedge, then check the registered outcome
    task automatic push(input logic [7:0] b, input bit v, input string ctx);
        bit            e_we = 1'b0;
        bit            e_err = 1'b0;
        logic [63:0]   e_data = '0;
        logic [AW-1:0] e_addr = '0;
        string         tag = "R3";
        if (!v) tag = "R9";
        else if (b[7]) begin
            if (m_cnt != 0) begin e_err = 1'b1; tag = "R6"; end
            m_acc = {57'b0, b[6:0]};
            m_cnt = 1;
        end else if (m_cnt == 0) begin
            e_err = 1'b1; tag = "R7";
        end else begin
            m_acc = {m_acc[56:0], b[6:0]};
            m_cnt++;
            if (m_cnt == 10) begin
                m_cnt = 0;
                if (!m_insn) begin
                    m_slot = m_acc[AW-1:0];
                    m_insn = 1'b1;
                end else begin
                    e_we = 1'b1; e_data = m_acc; e_addr = m_slot;
                    m_insn = 1'b0; tag = "R4";
                end
            end
        end
        if (ctx != "") tag = ctx;
        rx_byte  = b;
        rx_valid = v;
        @(negedge clk);
        rx_valid = 1'b0;
        check(mem_we == e_we, tag, "mem_we", 64'(mem_we), 64'(e_we));
        check(err_pulse == e_err, tag, "err_pulse", 64'(err_pulse), 64'(e_err));
        check(done_pulse == e_we, "R5", "done_pulse", 64'(done_pulse), 64'(e_we));
        if (e_we) begin
            check(mem_data == e_data, "R3", "mem_data", mem_data, e_data);
            check(mem_addr == e_addr, "R8", "mem_addr", 64'(mem_addr), 64'(e_addr));
        end
    endtask

    task automatic send_group(input logic [63:0] v, input string ctx);
        for (int i = 0; i < 10; i++) push(sym_of(v, i), 1'b1, ctx);
    endtask

    task automatic send_record(input logic [63:0] a, input logic [63:0] d, input string ctx);
        send_group(a, ctx);
        send_group(d, ctx);
    endtask

    initial begin
        logic [63:0] ra, rd;
        int unused_seed;
        unused_seed = $urandom(32'd4711);
        repeat (4) @(negedge clk);
        check(!mem_we && !err_pulse && !done_pulse, "R1", "strobes in reset",
              {61'b0, mem_we, err_pulse, done_pulse}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(mem_addr == '0 && mem_data == '0, "R1", "port after reset",
              mem_data | 64'(mem_addr), 64'd0);
        push(8'h05, 1'b1, "R1");                     // stray right after reset

        send_record(64'h3C, 64'hDEAD_BEEF_0123_4567, "R2");
        send_record(64'hFF, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
        send_record(64'h1234_5678_9ABC_DEF0, 64'h8000_0000_0000_0001, "R8");
        send_record(64'hF0, 64'h0BAD_F00D_CAFE_0042, "R8"); // same slot again

        // restart inside the address group
        for (int i = 0; i < 4; i++) push(sym_of(64'h77, i), 1'b1, "");
        send_record(64'h21, 64'h1111_2222_3333_4444, "R6");
        // restart inside the instruction group keeps the slot
        send_group(64'h5A, "R6");
        for (int i = 0; i < 5; i++) push(sym_of(64'h9999, i), 1'b1, "");
        send_group(64'h5555_6666_7777_8888, "R6");

        // idle cycles between bytes
        push(8'h80, 1'b0, "R9");
        send_group(64'h0A, "");
        push(8'h13, 1'b0, "R9");
        send_group(64'h0102_0304_0506_0708, "");

        // back-to-back records
        for (int k = 0; k < 3; k++)
            send_record(64'(k + 100), {32'(k), 32'hA5A5_5A5A}, "R10");

        // constrained random traffic
        for (int r = 0; r < 300; r++) begin
            ra = {$urandom, $urandom};
            rd = {$urandom, $urandom};
            for (int g = 0; g < 2; g++) begin
                for (int i = 0; i < 10; i++) begin
                    if ($urandom_range(7) == 0) push(8'($urandom), 1'b0, "");
                    if ($urandom_range(59) == 0) push({1'b0, 7'($urandom)}, 1'b1, "");
                    if ($urandom_range(79) == 0) push({1'b1, 7'($urandom)}, 1'b1, "");
                    push(sym_of(g == 0 ? ra : rd, i), 1'b1, "");
                end
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule